// File: doc/BRIEF.md
# Constant-Time Ladder Scalar Sequencer

This block steps a scalar multiplication through a two-register ladder. A secret scalar of `NK` bits is loaded together with a base point. The first state word starts at a fixed constant point, the neutral element, and the second starts at the base point. The bits are then consumed one at a time, starting from the most significant.

For each bit the sequence is always the same. The pair is conditionally exchanged under the bit. It is then sent to an external pair-update unit, which performs one combined double-and-add and returns the new pair. The same conditional exchange is then applied again.

The exchange is branch-free: a mask derived from the bit gates the XOR difference of the two words. The control path never selects on the key, and each bit costs the same cycles whatever its value. When the last bit is done, the first word holds `[k]P` and the second holds `[k+1]P`, and a one-cycle done pulse is raised.

Top module: `ladder_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `req_valid_o` are all low.
- R2: A start accepted while idle loads the first word with the constant `V1_INIT` and the second word with `base_i`. `req_p_o` carries `base_i` for the whole run.
- R3: Scalar bits are consumed from bit `NK-1` down to bit 0, one bit per update step.
- R4: The conditional exchange leaves the pair unchanged for bit value 0 and swaps the two words for bit value 1. It is applied both before and after every update. So the first request of a run carries (`V1_INIT`, `base_i`) when the top bit is 0, and (`base_i`, `V1_INIT`) when it is 1.
- R5: At done, `v1_o` equals `[k]P` and `v2_o` equals `[k+1]P` for the group computed by the pair-update unit.
- R6: A run issues exactly `NK` accepted requests, and `done_o` is raised only after the `NK`-th response. Each accepted request is followed by a cycle with `req_valid_o` low.
- R7: The number of cycles from start to done depends only on the pair-update unit's timing, never on the scalar bit values.
- R8: `start_i` is ignored while `busy_o` is high. The running computation finishes with its original scalar and base.
- R9: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o` stays high and the request payload stays stable.
- R10: `done_o` is a single-cycle pulse, coinciding with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only while idle) |
| scalar_i | input | NK | Secret scalar k |
| base_i | input | W | Base point P |
| req_valid_o | output | 1 | Update request valid |
| req_ready_i | input | 1 | Update unit accepts request |
| req_v1_o | output | W | First ladder word to update |
| req_v2_o | output | W | Second ladder word to update |
| req_p_o | output | W | Base point for the differential add |
| rsp_valid_i | input | 1 | Updated pair valid |
| rsp_v1_i | input | W | Updated first word |
| rsp_v2_i | input | W | Updated second word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| v1_o | output | W | Result [k]P |
| v2_o | output | W | Result [k+1]P |

## Verification
The bench replaces the update unit with an additive group modulo 251. In that group a correct ladder returns k·P and (k+1)·P. It drives scalars of all zeros, all ones, only the top bit, only the bottom bit and mixed patterns:
- Reversed bit order would mix up the top-bit and bottom-bit results.
- A missing or misplaced swap would break the outputs and the first-request payload.
- A key-dependent path would show up as a cycle count that differs from the zero-scalar run.

A start pulse injected mid-run catches a sequencer that reloads while busy. The ready line is held low for one cycle on every request, so a design that drops or changes its payload before acceptance trips the handshake checks.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWAP_PRE,
    ST_REQ,
    ST_WAIT,
    ST_SWAP_POST
  } ladder_st_e;
endpackage

// File: rtl/ladder_cswap.sv
module ladder_cswap #(
  parameter int W = 16
) (
  input  logic         sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic [W-1:0] mask;
  logic [W-1:0] diff;

  // masked xor exchange, no select driven by the key
  assign mask = {W{sel_i}};
  assign diff = (a_i ^ b_i) & mask;
  assign a_o  = a_i ^ diff;
  assign b_o  = b_i ^ diff;
endmodule

// File: rtl/ladder_keyreg.sv
module ladder_keyreg #(
  parameter int NK = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [NK-1:0] key_i,
  output logic          bit_o
);
  logic [NK-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      key_q <= '0;
    else if (load_i)  key_q <= key_i;
    else if (shift_i) key_q <= {key_q[NK-2:0], 1'b0};
  end

  assign bit_o = key_q[NK-1];
endmodule

// File: rtl/ladder_stepcnt.sv
module ladder_stepcnt #(
  parameter int NK = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (NK > 1) ? $clog2(NK) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == CW'(NK - 1));
endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
  import ladder_pkg::*;
#(
  parameter int           NK      = 256,
  parameter int           W       = 16,
  parameter logic [W-1:0] V1_INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NK-1:0] scalar_i,
  input  logic [W-1:0]  base_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [W-1:0]  req_v1_o,
  output logic [W-1:0]  req_v2_o,
  output logic [W-1:0]  req_p_o,
  input  logic          rsp_valid_i,
  input  logic [W-1:0]  rsp_v1_i,
  input  logic [W-1:0]  rsp_v2_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  v1_o,
  output logic [W-1:0]  v2_o
);
  ladder_st_e   state_q;
  logic [W-1:0] v1_q, v2_q, p_q;
  logic [W-1:0] sw_v1, sw_v2;
  logic         done_q;
  logic         key_bit;
  logic         last_step;
  logic         load;
  logic         step_end;

  assign load     = (state_q == ST_IDLE) && start_i;
  assign step_end = (state_q == ST_SWAP_POST);

  ladder_keyreg #(.NK(NK)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (step_end),
    .key_i   (scalar_i),
    .bit_o   (key_bit)
  );

  ladder_stepcnt #(.NK(NK)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .inc_i  (step_end),
    .last_o (last_step)
  );

  ladder_cswap #(.W(W)) u_swap (
    .sel_i (key_bit),
    .a_i   (v1_q),
    .b_i   (v2_q),
    .a_o   (sw_v1),
    .b_o   (sw_v2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      v1_q    <= '0;
      v2_q    <= '0;
      p_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            v1_q    <= V1_INIT;
            v2_q    <= base_i;
            p_q     <= base_i;
            state_q <= ST_SWAP_PRE;
          end
        end
        ST_SWAP_PRE: begin
          v1_q    <= sw_v1;
          v2_q    <= sw_v2;
          state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            v1_q    <= rsp_v1_i;
            v2_q    <= rsp_v2_i;
            state_q <= ST_SWAP_POST;
          end
        end
        ST_SWAP_POST: begin
          v1_q <= sw_v1;
          v2_q <= sw_v2;
          if (last_step) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SWAP_PRE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_v1_o    = v1_q;
  assign req_v2_o    = v2_q;
  assign req_p_o     = p_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign v1_o        = v1_q;
  assign v2_o        = v2_q;
endmodule

// File: rtl/ladder_seq_chk.sv
module ladder_seq_chk #(
  parameter int NK = 256,
  parameter int W  = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         req_valid_o,
  input logic         req_ready_i,
  input logic [W-1:0] req_v1_o,
  input logic [W-1:0] req_v2_o,
  input logic [W-1:0] req_p_o
);
  localparam int HW = $clog2(NK + 1) + 1;

  logic [HW-1:0] hs_cnt;
  logic          hs;

  assign hs = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hs_cnt <= '0;
    else if (start_i && !busy_o)  hs_cnt <= '0;
    else if (hs)                  hs_cnt <= hs_cnt + HW'(1);
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  p_step_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hs_cnt == HW'(NK));

  p_one_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> !req_valid_o);

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_v1_o) && $stable(req_v2_o) && $stable(req_p_o)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind ladder_seq ladder_seq_chk #(.NK(NK), .W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_v1_o    (req_v1_o),
  .req_v2_o    (req_v2_o),
  .req_p_o     (req_p_o)
);

// File: tb/ladder_seq_bench.sv
module ladder_seq_bench;
  localparam int NK = 256;
  localparam int W  = 16;
  localparam int Q  = 251;

  typedef struct {
    int    v1;
    int    v2;
    int    t0;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NK-1:0] scalar = '0;
  logic [W-1:0]  base = '0;
  logic          req_valid, req_ready;
  logic [W-1:0]  req_v1, req_v2, req_p;
  logic          rsp_valid;
  logic [W-1:0]  rsp_v1, rsp_v2;
  logic          busy, done;
  logic [W-1:0]  v1, v2;

  int   n_chk = 0, n_fail = 0, cyc = 0, hs_cnt = 0, ref_cyc = -1;
  exp_t q[$];
  bit   first_pend = 0;
  int   exp_f1, exp_f2, exp_p;
  bit   prev_done = 0;
  bit   pend = 0;
  int   lat = 0;

  always #5 clk = ~clk;

  ladder_seq #(.NK(NK), .W(W)) u_ladder_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scalar_i(scalar), .base_i(base),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_v1_o(req_v1),
    .req_v2_o(req_v2), .req_p_o(req_p), .rsp_valid_i(rsp_valid),
    .rsp_v1_i(rsp_v1), .rsp_v2_i(rsp_v2), .busy_o(busy), .done_o(done),
    .v1_o(v1), .v2_o(v2)
  );

  // toy pair-update unit: (a, b) -> (2a, a+b) mod Q, fixed timing
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0; rsp_valid <= 1'b0; rsp_v1 <= '0; rsp_v2 <= '0;
      pend <= 1'b0; lat <= 0;
    end else begin
      rsp_valid <= 1'b0;
      if (pend) begin
        if (lat == 0) begin rsp_valid <= 1'b1; pend <= 1'b0; end
        else lat <= lat - 1;
      end else if (req_valid && req_ready) begin
        pend <= 1'b1; lat <= 2; req_ready <= 1'b0;
        rsp_v1 <= W'((2 * int'(req_v1)) % Q);
        rsp_v2 <= W'((int'(req_v1) + int'(req_v2)) % Q);
      end else begin
        req_ready <= req_valid && !req_ready;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kmod(logic [NK-1:0] k);
    int acc = 0;
    for (int i = NK - 1; i >= 0; i--) acc = (acc * 2 + int'(k[i])) % Q;
    return acc;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!done, "R10 done pulse width", int'(done), 0);
      prev_done = done;
      if (req_valid && first_pend) begin
        first_pend = 0;
        chk(int'(req_v1) == exp_f1, "R4 first request word1", int'(req_v1), exp_f1);
        chk(int'(req_v2) == exp_f2, "R2 first request word2", int'(req_v2), exp_f2);
        chk(int'(req_p) == exp_p, "R2 base on request", int'(req_p), exp_p);
      end
      if (req_valid && req_ready) hs_cnt++;
      if (done) begin
        exp_t e;
        if (q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(int'(v1) == e.v1, {e.tag, " v1=[k]P"}, int'(v1), e.v1);
          chk(int'(v2) == e.v2, {e.tag, " v2=[k+1]P"}, int'(v2), e.v2);
          chk(hs_cnt == NK, "R6 update count", hs_cnt, NK);
          chk(!busy, "R10 idle at done", int'(busy), 0);
          if (ref_cyc < 0) ref_cyc = cyc - e.t0;
          else chk(cyc - e.t0 == ref_cyc, "R7 constant cycles", cyc - e.t0, ref_cyc);
        end
      end
    end
  end

  // driver
  task automatic run(logic [NK-1:0] k, int p, string tag, bit interfere);
    exp_t e;
    int   km;
    @(negedge clk);
    while (busy) @(negedge clk);
    km    = kmod(k);
    e.v1  = (km * p) % Q;
    e.v2  = (((km + 1) % Q) * p) % Q;
    e.t0  = cyc;
    e.tag = tag;
    q.push_back(e);
    exp_f1 = k[NK-1] ? p : 0;
    exp_f2 = k[NK-1] ? 0 : p;
    exp_p  = p;
    first_pend = 1;
    hs_cnt = 0;
    scalar = k; base = W'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (interfere) begin
      repeat (60) @(negedge clk);
      scalar = ~k; base = W'(p + 3); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(!req_valid, "R1 req_valid after reset", int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run('0, 7, "R5 zero scalar", 0);
    run(NK'(1), 13, "R3 bit0 only", 0);
    run({1'b1, {(NK-1){1'b0}}}, 13, "R3 top bit only", 0);
    run({NK{1'b1}}, 250, "R4 all ones", 0);
    run({64{4'hA}}, 99, "R5 alternating", 0);
    run({8{32'h1d2c_5b7e}}, 200, "R5 mixed", 0);
    run({8{32'hc3a5_0f96}}, 41, "R8 start while busy", 1);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R6 all runs done", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule